// File: doc/BRIEF.md
# Framed Stream Register Access Engine

This block is a small command slave that sits on an 8-bit byte stream. Every beat on either side carries a data byte, a valid/accept handshake and start-of-frame and end-of-frame flags. A command frame opens with a header byte. The low nibble of the header chooses the operation: code 0 reads the single internal 8-bit register, and code 1 writes it.

A read command is one beat that has both frame flags set. A write command is two beats: a header beat with only start set, then a data beat that ends the frame. The engine answers every legal command with a reply frame. The reply begins with the header byte echoed and flagged as start. A read reply then carries the register contents. Every reply ends with a separate closing beat that carries a fixed stop byte and the end flag.

Backpressure is honoured in both directions. The engine takes input only when it is ready for a command or for write data. It holds each reply beat steady until the downstream side accepts it.

Top module: `frame_regaccess`

## Requirements
- R1: While reset is asserted, `out_valid` and `in_accept` are low. The internal register resets to 8'h00, so a read issued before any write returns 8'h00.
- R2: The controller leaves its idle state one clock after the synchronised reset is released. The reset synchroniser has two stages, so `in_accept` first rises after the third rising clock edge that follows the release. `in_accept` is high only while the engine waits for a header or for write data.
- R3: A header beat with start=1, stop=1 and low nibble 0 is a read. Its reply has three beats: the header with start=1, then the register byte with both flags clear, then the stop byte 8'hA5 with stop=1.
- R4: A header beat with start=1, stop=0 and low nibble 1 is a write. The next accepted beat with stop=1 is stored in the register. The reply has two beats: the header with start=1, then 8'hA5 with stop=1.
- R5: A beat that reaches the idle-ready state without matching either legal header pattern is accepted and discarded. The engine produces no reply and stays ready for a header.
- R6: While the engine waits for write data, an accepted beat with stop=0 is discarded. The engine keeps waiting, and the register keeps its old value.
- R7: While `out_valid` is high and `out_accept` is low, `out_data`, `out_sof` and `out_eof` hold their values into the next cycle.
- R8: `out_sof` and `out_eof` are set only on a valid beat and never together. The start flag appears only on the first reply beat and the stop flag only on the last.
- R9: Once the engine has left the header-wait state, the stored header's low nibble is always the read code or the write code.
- R10: The controller state encoding stays within the values 0 to 6.
- R11: The echoed first reply beat carries the full header byte, including its upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it internally in step with the clock |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command beat present |
| in_sof | input | 1 | Command beat opens a frame |
| in_eof | input | 1 | Command beat closes a frame |
| in_accept | output | 1 | Engine takes the command beat this cycle |
| out_data | output | 8 | Reply stream byte |
| out_valid | output | 1 | Reply beat present |
| out_sof | output | 1 | Reply beat opens a frame |
| out_eof | output | 1 | Reply beat closes a frame |
| out_accept | input | 1 | Downstream takes the reply beat this cycle |

## Verification
The reply outputs are decoded from the controller state without any further register.

A read header accepted at one edge produces its echo beat after the second edge that follows (through the read gap state). A write data beat produces its echo after the next edge. Each later reply beat appears one edge after the previous beat is accepted.

The monitor therefore samples on the falling edge. At that point it sees the beat that the next rising edge will consume, together with the accept value it has just chosen, and it compares against the queued expectation only when both valid and accept are high. The same sampling point makes the hold check exact under backpressure. The monitor also compares every stalled cycle against the values seen on the falling edge before it.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HDR    = 3'd1,
    ST_RDGAP  = 3'd2,
    ST_WRDATA = 3'd3,
    ST_ECHO   = 3'd4,
    ST_RDATA  = 3'd5,
    ST_CLOSE  = 3'd6
  } rfa_state_e;
endpackage

// File: rtl/rfa_reset_sync.sv
module rfa_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/rfa_store.sv
module rfa_store #(
  parameter int               DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (wr_en) val_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RESET_VAL;
    else        val_q <= val_d;
  end

  assign rd_data = val_q;
endmodule

// File: rtl/rfa_ctrl.sv
module rfa_ctrl
  import rfa_pkg::*;
#(
  parameter int               CMD_W      = 4,
  parameter logic [CMD_W-1:0] READ_CODE  = 'd0,
  parameter logic [CMD_W-1:0] WRITE_CODE = 'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             out_accept,
  input  logic [CMD_W-1:0] hdr_cmd,
  output rfa_state_e       state_q,
  output logic             in_accept,
  output logic             hdr_en,
  output logic             reg_en
);
  rfa_state_e state_d;
  logic       in_fire;
  logic       is_read_hdr;
  logic       is_write_hdr;

  assign in_accept    = (state_q == ST_HDR) || (state_q == ST_WRDATA);
  assign in_fire      = in_valid && in_accept;
  assign is_read_hdr  = in_sof && in_eof && (in_cmd == READ_CODE);
  assign is_write_hdr = in_sof && !in_eof && (in_cmd == WRITE_CODE);
  assign hdr_en       = (state_q == ST_HDR) && in_fire && in_sof;
  assign reg_en       = (state_q == ST_WRDATA) && in_fire && in_eof;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = ST_HDR;
      ST_HDR: begin
        if (in_fire && is_read_hdr)       state_d = ST_RDGAP;
        else if (in_fire && is_write_hdr) state_d = ST_WRDATA;
      end
      ST_RDGAP:  state_d = ST_ECHO;
      ST_WRDATA: if (reg_en) state_d = ST_ECHO;
      ST_ECHO: begin
        if (out_accept) state_d = (hdr_cmd == READ_CODE) ? ST_RDATA : ST_CLOSE;
      end
      ST_RDATA:  if (out_accept) state_d = ST_CLOSE;
      ST_CLOSE:  if (out_accept) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/rfa_out.sv
module rfa_out
  import rfa_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter logic [DATA_W-1:0] STOP_BYTE = 'hA5
) (
  input  rfa_state_e        state_q,
  input  logic [DATA_W-1:0] hdr_q,
  input  logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof
);
  always_comb begin
    out_data  = '0;
    out_valid = 1'b0;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    unique case (state_q)
      ST_ECHO: begin
        out_valid = 1'b1;
        out_sof   = 1'b1;
        out_data  = hdr_q;
      end
      ST_RDATA: begin
        out_valid = 1'b1;
        out_data  = reg_q;
      end
      ST_CLOSE: begin
        out_valid = 1'b1;
        out_eof   = 1'b1;
        out_data  = STOP_BYTE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frame_regaccess.sv
module frame_regaccess
  import rfa_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                CMD_W       = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0]  READ_CODE   = 'd0,
  parameter logic [CMD_W-1:0]  WRITE_CODE  = 'd1,
  parameter logic [DATA_W-1:0] STOP_BYTE   = 'hA5,
  parameter logic [DATA_W-1:0] REG_RESET   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_accept,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  input  logic              out_accept
);
  logic              rst_sn;
  rfa_state_e        state_q;
  logic [DATA_W-1:0] hdr_q;
  logic [DATA_W-1:0] reg_q;
  logic              hdr_en;
  logic              reg_en;

  rfa_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rfa_ctrl #(
    .CMD_W      (CMD_W),
    .READ_CODE  (READ_CODE),
    .WRITE_CODE (WRITE_CODE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .in_cmd     (in_data[CMD_W-1:0]),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .out_accept (out_accept),
    .hdr_cmd    (hdr_q[CMD_W-1:0]),
    .state_q    (state_q),
    .in_accept  (in_accept),
    .hdr_en     (hdr_en),
    .reg_en     (reg_en)
  );

  rfa_store #(.DATA_W(DATA_W), .RESET_VAL('0)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (hdr_en),
    .wr_data (in_data),
    .rd_data (hdr_q)
  );

  rfa_store #(.DATA_W(DATA_W), .RESET_VAL(REG_RESET)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (reg_en),
    .wr_data (in_data),
    .rd_data (reg_q)
  );

  rfa_out #(.DATA_W(DATA_W), .STOP_BYTE(STOP_BYTE)) u_out (
    .state_q   (state_q),
    .hdr_q     (hdr_q),
    .reg_q     (reg_q),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );
endmodule

// File: rtl/frame_regaccess_props.sv
module frame_regaccess_props #(
  parameter int               DATA_W     = 8,
  parameter int               CMD_W      = 4,
  parameter logic [CMD_W-1:0] READ_CODE  = 'd0,
  parameter logic [CMD_W-1:0] WRITE_CODE = 'd1
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic              in_accept,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eof,
  input logic              out_accept,
  input logic [2:0]        state_q,
  input logic [DATA_W-1:0] hdr_q
);
  assert_state_range_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q <= 3'd6);

  assert_leave_idle_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd0 |=> state_q == 3'd1);

  assert_accept_states_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    in_accept |-> (state_q == 3'd1 || state_q == 3'd3));

  assert_read_hdr_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd1 && in_valid && in_accept && in_sof && in_eof
    && in_data[CMD_W-1:0] == READ_CODE |=> state_q == 3'd2);

  assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd2 |=> state_q == 3'd4);

  assert_write_hdr_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd1 && in_valid && in_accept && in_sof && !in_eof
    && in_data[CMD_W-1:0] == WRITE_CODE |=> state_q == 3'd3);

  assert_hdr_capture_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd1 && in_valid && in_accept && in_sof |=> hdr_q == $past(in_data));

  assert_bad_hdr_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd1 && in_valid && in_accept
    && !(in_sof && in_eof && in_data[CMD_W-1:0] == READ_CODE)
    && !(in_sof && !in_eof && in_data[CMD_W-1:0] == WRITE_CODE) |=> state_q == 3'd1);

  assert_wr_wait_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd3 && !(in_valid && in_eof) |=> state_q == 3'd3);

  assert_close_done_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == 3'd6 && out_valid && out_accept |=> state_q == 3'd0);

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid && !out_accept |=> $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  assert_sof_valid_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    out_sof |-> out_valid && !out_eof);

  assert_eof_valid_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    out_eof |-> out_valid);

  assert_sof_drops_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    out_sof && out_accept |=> !out_sof);

  assert_eof_drops_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    out_eof && out_accept |=> !out_eof);

  assert_valid_states_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> state_q >= 3'd4 && state_q <= 3'd6);

  assert_hdr_legal_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q > 3'd1 |-> (hdr_q[CMD_W-1:0] == READ_CODE || hdr_q[CMD_W-1:0] == WRITE_CODE));

  assert_echo_hdr_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    out_sof |-> out_data == hdr_q);
endmodule

bind frame_regaccess frame_regaccess_props #(
  .DATA_W     (DATA_W),
  .CMD_W      (CMD_W),
  .READ_CODE  (READ_CODE),
  .WRITE_CODE (WRITE_CODE)
) u_props (.*);

// File: tb/frame_regaccess_test.sv
module frame_regaccess_test;
  localparam logic [7:0] STOP = 8'hA5;

  typedef struct {
    logic [7:0] d;
    logic       s;
    logic       e;
    string      tag;
  } beat_t;

  logic       clk;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid, in_sof, in_eof;
  logic       in_accept;
  logic [7:0] out_data;
  logic       out_valid, out_sof, out_eof;
  logic       out_accept;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    acc_mode = 0;
  beat_t exp_q[$];
  logic [7:0] reg_m = 8'h00;

  logic       have_prev = 1'b0;
  logic       prev_v, prev_a, prev_s, prev_e;
  logic [7:0] prev_d;

  frame_regaccess uut (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_accept(in_accept),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_accept(out_accept)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      out_accept = 1'b0;
      have_prev  = 1'b0;
    end else begin
      case (acc_mode)
        0:       out_accept = 1'b1;
        1:       out_accept = ($urandom % 3) != 0;
        default: out_accept = ($urandom % 4) == 0;
      endcase
      if (have_prev && prev_v && !prev_a) begin
        check(out_valid && out_data == prev_d && out_sof == prev_s && out_eof == prev_e,
              "R7", "stalled beat changed", {out_valid, out_sof, out_eof, out_data},
              {1'b1, prev_s, prev_e, prev_d});
      end
      if (out_valid || out_sof || out_eof)
        check(out_valid && !(out_sof && out_eof), "R8", "flag combination",
              {out_valid, out_sof, out_eof}, {1'b1, 2'b00});
      if (out_valid && out_accept) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected reply beat", {out_sof, out_eof, out_data}, 0);
        end else begin
          beat_t b;
          b = exp_q.pop_front();
          check(out_data == b.d && out_sof == b.s && out_eof == b.e, b.tag, "reply beat",
                {out_sof, out_eof, out_data}, {b.s, b.e, b.d});
        end
      end
      have_prev = 1'b1;
      prev_v = out_valid; prev_a = out_accept;
      prev_d = out_data;  prev_s = out_sof; prev_e = out_eof;
    end
  end

  task automatic push(input logic [7:0] d, input logic s, input logic e, input string tag);
    beat_t b;
    b.d = d; b.s = s; b.e = e; b.tag = tag;
    exp_q.push_back(b);
  endtask

  task automatic send(input logic [7:0] d, input logic s, input logic e);
    in_data = d; in_sof = s; in_eof = e; in_valid = 1'b1;
    while (!in_accept) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] hdr, input string tag);
    push(hdr, 1'b1, 1'b0, "R11");
    push(reg_m, 1'b0, 1'b0, tag);
    push(STOP, 1'b0, 1'b1, "R3");
    send(hdr, 1'b1, 1'b1);
  endtask

  task automatic do_write(input logic [7:0] hdr, input logic [7:0] d);
    push(hdr, 1'b1, 1'b0, "R4");
    push(STOP, 1'b0, 1'b1, "R4");
    send(hdr, 1'b1, 1'b0);
    send(d, 1'b0, 1'b1);
    reg_m = d;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_probe(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid && in_accept, tag, "engine not idle-ready",
            {out_valid, in_accept}, 2'b01);
    end
  endtask

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    check(!in_accept, "R1", "in_accept in reset", in_accept, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!in_accept, "R2", "accept before leaving idle", in_accept, 0);
    @(negedge clk);
    check(in_accept, "R2", "accept after leaving idle", in_accept, 1);

    // R1: reset value read back, R3 read frame
    do_read(8'h30, "R1");
    drain();
    // R4 write then read back
    do_write(8'h51, 8'h3C);
    drain();
    do_read(8'hE0, "R4");
    drain();

    // R5: illegal headers are swallowed
    send(8'h02, 1'b1, 1'b1); idle_probe("R5");
    send(8'h01, 1'b1, 1'b1); idle_probe("R5");
    send(8'h00, 1'b1, 1'b0); idle_probe("R5");
    send(8'h00, 1'b0, 1'b1); idle_probe("R5");
    do_read(8'h10, "R5");
    drain();

    // R6: non-final beat while waiting for write data
    push(8'h01, 1'b1, 1'b0, "R6");
    push(STOP, 1'b0, 1'b1, "R6");
    send(8'h01, 1'b1, 1'b0);
    send(8'h77, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid && in_accept, "R6", "still waiting for data",
            {out_valid, in_accept}, 2'b01);
    end
    send(8'h99, 1'b0, 1'b1);
    reg_m = 8'h99;
    drain();
    do_read(8'h00, "R6");
    drain();

    // R7: backpressure, mixed traffic
    for (int mode = 1; mode < 3; mode++) begin
      acc_mode = mode;
      for (int t = 0; t < 20; t++) begin
        logic [7:0] r;
        r = 8'($urandom);
        if (r[0]) do_write({r[7:4], 4'h1}, 8'($urandom));
        else      do_read({r[7:4], 4'h0}, "R7");
      end
      drain();
    end
    acc_mode = 0;
    drain();
    check(exp_q.size() == 0, "R3", "replies outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule